// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

This block is one byte-wide DMA channel that works through a circular list of buffer descriptors in a small descriptor memory. Each descriptor gives a transfer length, a source pointer and a destination pointer, along with flag bits. The channel moves one byte per operand. It gets bus ownership through a request/grant handshake and then runs one or two bus accesses for each operand. When a buffer closes, the channel writes the descriptor back with its valid flag cleared and a close reason recorded. It then raises the matching interrupt and moves on to the next descriptor.

Operands are started either by an external request line or by an internal request that is always present. Dual-address operation reads the source and then writes the destination. Single-address operation uses one access to the memory-side pointer while a device strobe is asserted, and the pointer on the device side is not used. A buffer can close in three ways: the count reaches zero, a bus error occurs on the destination side, or the external done line is asserted. The second and third reasons always interrupt. A zero-length descriptor is treated as a programming error and stops the channel.

Software uses a control register, a current-register access port and a reinitialise strobe. The current registers can be read at any time, but they can only be written while the channel is idle.

Top module: `dmar_chan`

## Requirements
- R1: After reset the channel is idle (`active` low). `bus_req`, `bus_cyc`, `desc_we` and all four interrupts are low, and every current register reads 0.
- R2: The control word bits are: bit0 start, bit1 hold (reset), bit2 internal request, bit3 dual address, bit4 device-is-source. While start is 0 the channel stays idle, ignores `dreq` and never raises `bus_req`.
- R3: In external mode (bit2 = 0), each cycle in which `dreq` is high while the channel waits between operands starts exactly one operand, which begins with bus arbitration. No operand runs without such a request. In internal mode (bit2 = 1), operands start back to back.
- R4: In dual-address mode each operand reads the byte at the current source address and writes it to the current destination address. Both addresses then increase by 1 and the count decreases by 1.
- R5: In single-address mode each operand is one access at the memory-side pointer with `dev_ack` high. With bit4 = 1 this is a write at the destination pointer; with bit4 = 0 it is a read at the source pointer. The device-side pointer is never put on the bus and is never changed.
- R6: The descriptor word, from MSB down, is: valid, interrupt, wrap, bus-error status, done status, count (CW bits), source (AW bits), destination (AW bits). When the count runs out, the descriptor is written back with valid = 0, both status bits 0 and the other fields unchanged. `irq_buf` pulses only if the interrupt bit is 1.
- R7: After a buffer closes, the ring index moves to the next entry. It moves to entry 0 if the wrap bit of the closed descriptor is 1 or if the closed entry is the last one.
- R8: If the descriptor at the ring index has valid = 0, the channel stays active and issues no bus request. It resumes as soon as that descriptor becomes valid.
- R9: A valid descriptor with count 0 pulses `irq_err` and clears the start bit. No bus access is made and the descriptor is left unchanged.
- R10: A bus error on a destination access closes the buffer after that operand. The write-back has valid = 0 and the bus-error status set, and `irq_berr` pulses whatever the interrupt bit is. A single-address access counts as a destination access.
- R11: If `done_in` is high when an operand completes, the buffer closes after that operand. The write-back has valid = 0 and the done status set, and `irq_done` pulses whatever the interrupt bit is.
- R12: `reg_sel` selects a current register: 0 source, 1 destination, 2 count, 3 function code. Writes through `reg_wr` take effect only while `active` is low; while active they are discarded and the read value is unchanged.
- R13: A `reinit` pulse while the hold bit is 1 returns the channel to idle, clears the current registers and sets the ring index to 0. With hold at 0 the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word (R2 bit layout) |
| reinit | input | 1 | Reinitialise command pulse |
| reg_wr | input | 1 | Current-register write strobe |
| reg_sel | input | 2 | Current-register select |
| reg_wdata | input | AW | Current-register write data |
| reg_rdata | output | AW | Selected current register, zero-extended |
| active | output | 1 | Channel is not idle |
| dreq | input | 1 | External operand request |
| done_in | input | 1 | External done |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | Access in progress |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access ended in error |
| bus_fc | output | FCW | Function code for accesses |
| dev_ack | output | 1 | Device strobe for single-address accesses |
| desc_idx | output | IW | Descriptor memory index (ring position) |
| desc_rdata | input | DW | Descriptor read data (combinational) |
| desc_we | output | 1 | Descriptor write-back strobe |
| desc_wdata | output | DW | Descriptor write-back data |
| irq_buf | output | 1 | Normal completion interrupt pulse |
| irq_berr | output | 1 | Destination bus-error interrupt pulse |
| irq_done | output | 1 | External-done interrupt pulse |
| irq_err | output | 1 | Zero-count programming-error pulse |

## Verification
A wrong ring index shows up within one buffer. The write-back lands in the wrong descriptor slot and `desc_idx` points to the wrong entry while the channel halts. A wrong close-reason register shows up on the single cycle of write-back: the wrong status bit is set, or the wrong interrupt or none at all is raised. Address or count stepping faults become visible at the end of the buffer, as misplaced bytes in the bus memory and wrong current-register read values. These values are compared against copies computed from the descriptor contents.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_ARB,
      ST_RD,
      ST_WR,
      ST_ONE,
      ST_CLOSE
   } eng_st_e;

   typedef enum logic [1:0] {
      CL_NORM,
      CL_BERR,
      CL_DONE
   } close_e;

   typedef struct packed {
      logic devsrc;
      logic dual;
      logic intreq;
      logic hold;
      logic start;
   } ctl_t;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;
   localparam logic [1:0] SEL_FC  = 2'd3;

endpackage

// File: rtl/dmar_ctl.sv
module dmar_ctl
   import dmar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [4:0] wdata,
   input  logic       reinit,
   input  logic       stop,
   output ctl_t       ctl,
   output logic       reinit_ok
);

   ctl_t ctl_q;

   assign reinit_ok = reinit & ctl_q.hold;
   assign ctl       = ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr) begin
            ctl_q <= ctl_t'(wdata);
         end
         if (stop || reinit_ok) begin
            ctl_q.start <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dmar_regs.sv
module dmar_regs
   import dmar_pkg::*;
#(
   parameter int AW  = 16,
   parameter int CW  = 8,
   parameter int FCW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           busy,
   input  logic           load,
   input  logic [AW-1:0]  ld_src,
   input  logic [AW-1:0]  ld_dst,
   input  logic [CW-1:0]  ld_cnt,
   input  logic           step,
   input  logic           step_src,
   input  logic           step_dst,
   input  logic           sw_wr,
   input  logic [1:0]     sw_sel,
   input  logic [AW-1:0]  sw_wdata,
   output logic [AW-1:0]  sw_rdata,
   output logic [AW-1:0]  cur_src,
   output logic [AW-1:0]  cur_dst,
   output logic [CW-1:0]  cur_cnt,
   output logic [FCW-1:0] cur_fc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src <= '0;
         cur_dst <= '0;
         cur_cnt <= '0;
         cur_fc  <= '0;
      end else if (clr) begin
         cur_src <= '0;
         cur_dst <= '0;
         cur_cnt <= '0;
         cur_fc  <= '0;
      end else if (load) begin
         cur_src <= ld_src;
         cur_dst <= ld_dst;
         cur_cnt <= ld_cnt;
      end else if (step) begin
         if (step_src) cur_src <= cur_src + 1'b1;
         if (step_dst) cur_dst <= cur_dst + 1'b1;
         cur_cnt <= cur_cnt - 1'b1;
      end else if (sw_wr && !busy) begin
         case (sw_sel)
            SEL_SRC: cur_src <= sw_wdata;
            SEL_DST: cur_dst <= sw_wdata;
            SEL_CNT: cur_cnt <= sw_wdata[CW-1:0];
            default: cur_fc  <= sw_wdata[FCW-1:0];
         endcase
      end
   end

   always_comb begin
      case (sw_sel)
         SEL_SRC: sw_rdata = cur_src;
         SEL_DST: sw_rdata = cur_dst;
         SEL_CNT: sw_rdata = AW'(cur_cnt);
         default: sw_rdata = AW'(cur_fc);
      endcase
   end

endmodule

// File: rtl/dmar_ring.sv
module dmar_ring #(
   parameter int DEPTH = 4,
   parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic          wrap,
   output logic [IW-1:0] idx
);

   logic [IW-1:0] nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign nxt = idx + 1'b1;
      end else begin : g_odd
         assign nxt = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (adv) begin
         idx <= wrap ? '0 : nxt;
      end
   end

endmodule

// File: rtl/dmar_engine.sv
module dmar_engine
   import dmar_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 8,
   parameter int DW = 5 + CW + 2 * AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          go,
   input  logic          intreq,
   input  logic          dual,
   input  logic          devsrc,
   input  logic          dreq,
   input  logic          done_in,
   input  logic [DW-1:0] desc_rdata,
   input  logic [AW-1:0] cur_src,
   input  logic [AW-1:0] cur_dst,
   input  logic [CW-1:0] cur_cnt,
   input  logic          bus_gnt,
   input  logic          bus_ack,
   input  logic          bus_err,
   input  logic [7:0]    bus_rdata,
   output logic          busy,
   output logic          load,
   output logic          stop,
   output logic          step,
   output logic          step_src,
   output logic          step_dst,
   output logic          bus_req,
   output logic          bus_cyc,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_wdata,
   output logic          dev_ack,
   output logic          desc_we,
   output logic [DW-1:0] desc_wdata,
   output logic          adv,
   output logic          adv_wrap,
   output logic          irq_buf,
   output logic          irq_berr,
   output logic          irq_done,
   output logic          irq_err
);

   localparam int V_B  = DW - 1;
   localparam int I_B  = DW - 2;
   localparam int W_B  = DW - 3;
   localparam int D_B  = DW - 5;
   localparam int C_LO = 2 * AW;
   localparam int C_HI = 2 * AW + CW - 1;

   eng_st_e       st;
   close_e        rsn;
   logic [DW-1:0] desc_q;
   logic [7:0]    rd_q;
   logic          dvalid;
   logic          dzero;
   logic          req;
   logic          fin;

   assign dvalid = desc_rdata[V_B];
   assign dzero  = (desc_rdata[C_HI:C_LO] == '0);
   assign req    = intreq | dreq;
   assign fin    = ((st == ST_WR) || (st == ST_ONE)) && (bus_ack || bus_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         rsn    <= CL_NORM;
         desc_q <= '0;
         rd_q   <= '0;
      end else if (clr) begin
         st     <= ST_IDLE;
         rsn    <= CL_NORM;
         desc_q <= '0;
         rd_q   <= '0;
      end else begin
         case (st)
            ST_IDLE:  if (go) st <= ST_FETCH;
            ST_FETCH: begin
               if (!go) begin
                  st <= ST_IDLE;
               end else if (dvalid) begin
                  if (dzero) begin
                     st <= ST_IDLE;
                  end else begin
                     desc_q <= desc_rdata;
                     st     <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (!go)      st <= ST_IDLE;
               else if (req) st <= ST_ARB;
            end
            ST_ARB:   if (bus_gnt) st <= dual ? ST_RD : ST_ONE;
            ST_RD: begin
               if (bus_ack || bus_err) begin
                  rd_q <= bus_rdata;
                  st   <= ST_WR;
               end
            end
            ST_WR, ST_ONE: begin
               if (bus_ack || bus_err) begin
                  if (bus_err)      rsn <= CL_BERR;
                  else if (done_in) rsn <= CL_DONE;
                  else              rsn <= CL_NORM;
                  if (bus_err || done_in || (cur_cnt == CW'(1))) st <= ST_CLOSE;
                  else                                           st <= ST_WAIT;
               end
            end
            default:  st <= ST_FETCH;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign load     = (st == ST_FETCH) && go && dvalid && !dzero;
   assign stop     = (st == ST_FETCH) && go && dvalid && dzero;
   assign irq_err  = stop;
   assign step     = fin;
   assign step_src = fin && (dual || !devsrc);
   assign step_dst = fin && (dual || devsrc);

   assign bus_req  = (st == ST_ARB) || (st == ST_RD) || (st == ST_WR) || (st == ST_ONE);
   assign bus_cyc  = (st == ST_RD) || (st == ST_WR) || (st == ST_ONE);
   assign bus_we   = (st == ST_WR) || ((st == ST_ONE) && devsrc);
   assign dev_ack  = (st == ST_ONE);
   assign bus_wdata = (st == ST_WR) ? rd_q : 8'h00;

   always_comb begin
      case (st)
         ST_RD:   bus_addr = cur_src;
         ST_WR:   bus_addr = cur_dst;
         ST_ONE:  bus_addr = devsrc ? cur_dst : cur_src;
         default: bus_addr = '0;
      endcase
   end

   assign desc_we    = (st == ST_CLOSE);
   assign desc_wdata = {1'b0, desc_q[I_B], desc_q[W_B], (rsn == CL_BERR), (rsn == CL_DONE),
                        desc_q[D_B-1:0]};
   assign adv        = (st == ST_CLOSE);
   assign adv_wrap   = desc_q[W_B];
   assign irq_buf    = (st == ST_CLOSE) && (rsn == CL_NORM) && desc_q[I_B];
   assign irq_berr   = (st == ST_CLOSE) && (rsn == CL_BERR);
   assign irq_done   = (st == ST_CLOSE) && (rsn == CL_DONE);

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
   import dmar_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 8,
   parameter int FCW   = 3,
   parameter int DEPTH = 4,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int DW   = 5 + CW + 2 * AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctl_wr,
   input  logic [4:0]     ctl_wdata,
   input  logic           reinit,
   input  logic           reg_wr,
   input  logic [1:0]     reg_sel,
   input  logic [AW-1:0]  reg_wdata,
   output logic [AW-1:0]  reg_rdata,
   output logic           active,
   input  logic           dreq,
   input  logic           done_in,
   output logic           bus_req,
   input  logic           bus_gnt,
   output logic           bus_cyc,
   output logic           bus_we,
   output logic [AW-1:0]  bus_addr,
   output logic [7:0]     bus_wdata,
   input  logic [7:0]     bus_rdata,
   input  logic           bus_ack,
   input  logic           bus_err,
   output logic [FCW-1:0] bus_fc,
   output logic           dev_ack,
   output logic [IW-1:0]  desc_idx,
   input  logic [DW-1:0]  desc_rdata,
   output logic           desc_we,
   output logic [DW-1:0]  desc_wdata,
   output logic           irq_buf,
   output logic           irq_berr,
   output logic           irq_done,
   output logic           irq_err
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("dmar_chan: AW must be at least 8");
      end
      if (CW < 1 || CW > AW) begin : g_bad_cw
         $error("dmar_chan: CW must lie in 1..AW");
      end
      if (FCW < 1 || FCW > AW) begin : g_bad_fcw
         $error("dmar_chan: FCW must lie in 1..AW");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("dmar_chan: DEPTH must be at least 2");
      end
   endgenerate

   ctl_t          ctl;
   logic          reinit_ok;
   logic          stop;
   logic          go;
   logic          busy;
   logic          load;
   logic          step;
   logic          step_src;
   logic          step_dst;
   logic          adv;
   logic          adv_wrap;
   logic [AW-1:0] cur_src;
   logic [AW-1:0] cur_dst;
   logic [CW-1:0] cur_cnt;

   assign go     = ctl.start & ~ctl.hold;
   assign active = busy;

   dmar_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .wdata     (ctl_wdata),
      .reinit    (reinit),
      .stop      (stop),
      .ctl       (ctl),
      .reinit_ok (reinit_ok)
   );

   dmar_regs #(.AW(AW), .CW(CW), .FCW(FCW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (reinit_ok),
      .busy     (busy),
      .load     (load),
      .ld_src   (desc_rdata[2*AW-1:AW]),
      .ld_dst   (desc_rdata[AW-1:0]),
      .ld_cnt   (desc_rdata[2*AW+CW-1:2*AW]),
      .step     (step),
      .step_src (step_src),
      .step_dst (step_dst),
      .sw_wr    (reg_wr),
      .sw_sel   (reg_sel),
      .sw_wdata (reg_wdata),
      .sw_rdata (reg_rdata),
      .cur_src  (cur_src),
      .cur_dst  (cur_dst),
      .cur_cnt  (cur_cnt),
      .cur_fc   (bus_fc)
   );

   dmar_ring #(.DEPTH(DEPTH), .IW(IW)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (reinit_ok),
      .adv   (adv),
      .wrap  (adv_wrap),
      .idx   (desc_idx)
   );

   dmar_engine #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (reinit_ok),
      .go         (go),
      .intreq     (ctl.intreq),
      .dual       (ctl.dual),
      .devsrc     (ctl.devsrc),
      .dreq       (dreq),
      .done_in    (done_in),
      .desc_rdata (desc_rdata),
      .cur_src    (cur_src),
      .cur_dst    (cur_dst),
      .cur_cnt    (cur_cnt),
      .bus_gnt    (bus_gnt),
      .bus_ack    (bus_ack),
      .bus_err    (bus_err),
      .bus_rdata  (bus_rdata),
      .busy       (busy),
      .load       (load),
      .stop       (stop),
      .step       (step),
      .step_src   (step_src),
      .step_dst   (step_dst),
      .bus_req    (bus_req),
      .bus_cyc    (bus_cyc),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .dev_ack    (dev_ack),
      .desc_we    (desc_we),
      .desc_wdata (desc_wdata),
      .adv        (adv),
      .adv_wrap   (adv_wrap),
      .irq_buf    (irq_buf),
      .irq_berr   (irq_berr),
      .irq_done   (irq_done),
      .irq_err    (irq_err)
   );

endmodule

// File: rtl/dmar_chan_chk.sv
module dmar_chan_chk #(
   parameter int DW = 45
) (
   input logic          clk,
   input logic          rst_n,
   input logic          active,
   input logic          bus_req,
   input logic          bus_cyc,
   input logic          dev_ack,
   input logic          desc_we,
   input logic [DW-1:0] desc_wdata,
   input logic          irq_buf,
   input logic          irq_berr,
   input logic          irq_done,
   input logic          irq_err
);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !bus_req);

   // R5
   dev_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (bus_cyc && bus_req));

   // R6
   buf_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_buf |-> (desc_we && !desc_wdata[DW-1] && desc_wdata[DW-2]
                   && !desc_wdata[DW-4] && !desc_wdata[DW-5]));

   // R6
   one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_buf, irq_berr, irq_done, irq_err}));

   // R9
   zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |=> (!active && !bus_req));

   // R10
   berr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_berr |-> (desc_we && !desc_wdata[DW-1] && desc_wdata[DW-4] && !desc_wdata[DW-5]));

   // R11
   done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> (desc_we && !desc_wdata[DW-1] && desc_wdata[DW-5] && !desc_wdata[DW-4]));

endmodule

bind dmar_chan dmar_chan_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .active     (active),
   .bus_req    (bus_req),
   .bus_cyc    (bus_cyc),
   .dev_ack    (dev_ack),
   .desc_we    (desc_we),
   .desc_wdata (desc_wdata),
   .irq_buf    (irq_buf),
   .irq_berr   (irq_berr),
   .irq_done   (irq_done),
   .irq_err    (irq_err)
);

// File: tb/sim_dmar_chan.sv
`timescale 1ns/1ps
module sim_dmar_chan;

   localparam int AW = 16, CW = 8, FCW = 3, DEPTH = 4, IW = 2;
   localparam int DW = 5 + CW + 2 * AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [4:0]    ctl_wdata = '0;
   logic          reinit = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic          active;
   logic          dreq = 1'b0;
   logic          done_in = 1'b0;
   logic          bus_req, bus_cyc, bus_we, dev_ack;
   logic          bus_gnt = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata, bus_rdata;
   logic [FCW-1:0] bus_fc;
   logic [IW-1:0] desc_idx;
   logic [DW-1:0] desc_rdata, desc_wdata;
   logic          desc_we, irq_buf, irq_berr, irq_done, irq_err;

   logic [DW-1:0] dmem [0:DEPTH-1];
   logic [7:0]    bmem [0:255];

   int checks = 0, errors = 0;
   int n_buf = 0, n_berr = 0, n_done = 0, n_err = 0, n_wb = 0;
   int n_req = 0, n_dev = 0, n_watch = 0;
   logic          err_en = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic [AW-1:0] watch_addr = 16'hFFFF;

   always #10 clk = ~clk;   // 50 MHz

   dmar_chan #(.AW(AW), .CW(CW), .FCW(FCW), .DEPTH(DEPTH)) u0 (.*);

   assign desc_rdata = dmem[desc_idx];
   assign bus_rdata  = bmem[bus_addr[7:0]];

   // bus slave, descriptor memory write port and event counters
   always @(posedge clk) begin
      bus_gnt <= bus_req;
      if (bus_cyc && !bus_ack && !bus_err && ($urandom % 3 != 0)) begin
         if (err_en && bus_we && bus_addr == err_addr) begin
            bus_err <= 1'b1;
         end else begin
            bus_ack <= 1'b1;
            if (bus_we) bmem[bus_addr[7:0]] <= bus_wdata;
         end
         if (dev_ack) n_dev++;
         if (bus_addr == watch_addr) n_watch++;
      end else begin
         bus_ack <= 1'b0;
         bus_err <= 1'b0;
      end
      if (desc_we) begin
         dmem[desc_idx] <= desc_wdata;
         n_wb++;
      end
      if (bus_req)  n_req++;
      if (irq_buf)  n_buf++;
      if (irq_berr) n_berr++;
      if (irq_done) n_done++;
      if (irq_err)  n_err++;
   end

   function automatic logic [DW-1:0] mkdesc(input logic v, input logic i, input logic w,
                                            input logic [CW-1:0] c, input logic [AW-1:0] s,
                                            input logic [AW-1:0] d);
      return {v, i, w, 2'b00, c, s, d};
   endfunction

   function automatic logic [DW-1:0] closed(input logic [DW-1:0] d, input logic e, input logic dn);
      return {1'b0, d[DW-2], d[DW-3], e, dn, d[DW-6:0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctl_wr = 0; reinit = 0; reg_wr = 0; dreq = 0; done_in = 0; err_en = 0;
      for (int k = 0; k < DEPTH; k++) dmem[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [4:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic rdreg(input logic [1:0] s, output logic [AW-1:0] v);
      @(negedge clk); reg_sel = s; #1 v = reg_rdata;
   endtask

   task automatic wait_wb(input string tag);
      int base = n_wb;
      int lim = 0;
      while (n_wb == base && lim < 5000) begin @(negedge clk); lim++; end
      chk(tag, 64'(n_wb > base), 64'd1);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_dreq();
      @(negedge clk); dreq = 1'b1;
      @(negedge clk); dreq = 1'b0;
      repeat (30) @(negedge clk);
   endtask

   task automatic copy_chk(input string tag, input int s, input int d, input int n);
      int bad = 0;
      for (int k = 0; k < n; k++) if (bmem[d + k] !== bmem[s + k]) bad++;
      chk(tag, 64'(bad), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] v;
      int b0, b1, b2, b3;
      logic [DW-1:0] d;
      void'($urandom(32'd7311));
      for (int k = 0; k < 256; k++) bmem[k] = 8'($urandom);

      // R1: reset state
      do_reset();
      chk("R1 active", 64'(active), 0);
      chk("R1 outputs", 64'({bus_req, bus_cyc, desc_we, irq_buf, irq_berr, irq_done, irq_err}), 0);
      rdreg(2'd0, v); chk("R1 src reg", 64'(v), 0);
      rdreg(2'd2, v); chk("R1 cnt reg", 64'(v), 0);

      // R2: no start, dreq ignored
      dmem[0] = mkdesc(1, 1, 0, 8'd2, 16'h10, 16'h40);
      wr_ctl(5'b01000);
      b0 = n_req;
      for (int k = 0; k < 5; k++) pulse_dreq();
      chk("R2 no bus_req", 64'(n_req - b0), 0);
      chk("R2 idle", 64'(active), 0);

      // R4 R6 R7 R8 R12: dual internal
      do_reset();
      d = mkdesc(1, 1, 0, 8'd6, 16'h10, 16'h40);
      dmem[0] = d; dmem[1] = mkdesc(0, 0, 0, 8'd3, 16'h20, 16'h60);
      b0 = n_buf;
      wr_ctl(5'b01101);
      wait_wb("R6 close seen");
      copy_chk("R4 dual copy", 16'h10, 16'h40, 6);
      chk("R6 irq_buf with intr", 64'(n_buf - b0), 1);
      chk("R6 write-back", 64'(dmem[0]), 64'(closed(d, 0, 0)));
      rdreg(2'd0, v); chk("R4 src stepped", 64'(v), 64'h16);
      rdreg(2'd1, v); chk("R4 dst stepped", 64'(v), 64'h46);
      rdreg(2'd2, v); chk("R4 cnt zero", 64'(v), 0);
      b1 = n_req;
      repeat (40) @(negedge clk);
      chk("R8 halted no req", 64'(n_req - b1), 0);
      chk("R8 still active", 64'(active), 1);
      chk("R7 idx advanced", 64'(desc_idx), 1);
      @(negedge clk); reg_wr = 1; reg_sel = 2'd0; reg_wdata = 16'h1234;
      @(negedge clk); reg_wr = 0;
      rdreg(2'd0, v); chk("R12 write discarded", 64'(v), 64'h16);

      // R8 resume, R6 no irq, R7 wrap
      b0 = n_buf;
      @(negedge clk); dmem[1] = mkdesc(1, 0, 1, 8'd3, 16'h20, 16'h60);
      wait_wb("R8 resumed");
      copy_chk("R4 second buffer", 16'h20, 16'h60, 3);
      chk("R6 no irq when intr clear", 64'(n_buf - b0), 0);
      chk("R7 wrap to 0", 64'(desc_idx), 0);

      // R3 external mode, R13 reinit
      do_reset();
      dmem[0] = mkdesc(1, 1, 0, 8'd3, 16'h30, 16'h70);
      wr_ctl(5'b01001);
      b0 = n_req;
      repeat (30) @(negedge clk);
      chk("R3 no req without dreq", 64'(n_req - b0), 0);
      rdreg(2'd2, v); chk("R3 cnt untouched", 64'(v), 3);
      pulse_dreq();
      rdreg(2'd2, v); chk("R3 one operand per dreq", 64'(v), 2);
      chk("R3 byte moved", 64'(bmem[8'h70]), 64'(bmem[8'h30]));
      pulse_dreq(); pulse_dreq();
      chk("R3 buffer closed", 64'(dmem[0][DW-1]), 0);
      chk("R7 idx 1", 64'(desc_idx), 1);
      @(negedge clk); reinit = 1; @(negedge clk); reinit = 0;
      repeat (4) @(negedge clk);
      chk("R13 reinit ignored idx", 64'(desc_idx), 1);
      chk("R13 reinit ignored active", 64'(active), 1);
      wr_ctl(5'b01011);
      @(negedge clk); reinit = 1; @(negedge clk); reinit = 0;
      repeat (2) @(negedge clk);
      chk("R13 idx reset", 64'(desc_idx), 0);
      chk("R13 idle", 64'(active), 0);
      rdreg(2'd0, v); chk("R13 regs cleared", 64'(v), 0);
      @(negedge clk); reg_wr = 1; reg_sel = 2'd3; reg_wdata = 16'h5;
      @(negedge clk); reg_wr = 0;
      rdreg(2'd3, v); chk("R12 write while idle", 64'(v), 5);

      // R10 destination bus error
      do_reset();
      d = mkdesc(1, 0, 0, 8'd5, 16'h10, 16'h50);
      dmem[0] = d;
      err_en = 1; err_addr = 16'h52;
      b0 = n_berr; b1 = n_buf;
      wr_ctl(5'b01101);
      wait_wb("R10 close seen");
      err_en = 0;
      chk("R10 irq_berr forced", 64'(n_berr - b0), 1);
      chk("R10 no buf irq", 64'(n_buf - b1), 0);
      chk("R10 write-back", 64'(dmem[0]), 64'(closed(d, 1, 0)));
      rdreg(2'd2, v); chk("R10 closed after third", 64'(v), 2);

      // R11 external done
      do_reset();
      d = mkdesc(1, 0, 0, 8'd4, 16'h10, 16'h58);
      dmem[0] = d;
      done_in = 1;
      b0 = n_done;
      wr_ctl(5'b01101);
      wait_wb("R11 close seen");
      done_in = 0;
      chk("R11 irq_done forced", 64'(n_done - b0), 1);
      chk("R11 write-back", 64'(dmem[0]), 64'(closed(d, 0, 1)));
      rdreg(2'd2, v); chk("R11 one operand", 64'(v), 3);
      chk("R11 byte moved", 64'(bmem[8'h58]), 64'(bmem[8'h10]));

      // R9 zero count
      do_reset();
      d = mkdesc(1, 1, 0, 8'd0, 16'h10, 16'h40);
      dmem[0] = d;
      b0 = n_err; b1 = n_req; b2 = n_wb;
      wr_ctl(5'b01101);
      repeat (20) @(negedge clk);
      chk("R9 irq_err", 64'(n_err - b0), 1);
      chk("R9 stopped", 64'(active), 0);
      chk("R9 no bus access", 64'(n_req - b1), 0);
      chk("R9 descriptor untouched", 64'(dmem[0]) | 64'(n_wb - b2), 64'(d));

      // R5 single address, device is source
      do_reset();
      dmem[0] = mkdesc(1, 1, 0, 8'd3, 16'hEE, 16'h80);
      watch_addr = 16'hEE;
      b0 = n_watch; b1 = n_dev;
      wr_ctl(5'b10101);
      wait_wb("R5 close seen");
      chk("R5 device pointer unused", 64'(n_watch - b0), 0);
      chk("R5 strobed accesses", 64'(n_dev - b1), 3);
      rdreg(2'd0, v); chk("R5 device pointer kept", 64'(v), 64'hEE);
      rdreg(2'd1, v); chk("R5 memory pointer stepped", 64'(v), 64'h83);

      // R5 single address, device is destination
      do_reset();
      dmem[0] = mkdesc(1, 1, 0, 8'd2, 16'h24, 16'h99);
      watch_addr = 16'h99;
      b0 = n_watch;
      wr_ctl(5'b00101);
      wait_wb("R5 close seen b");
      chk("R5 device dest unused", 64'(n_watch - b0), 0);
      rdreg(2'd1, v); chk("R5 dest pointer kept", 64'(v), 64'h99);
      watch_addr = 16'hFFFF;

      // R4 R6: random buffers
      for (int it = 0; it < 6; it++) begin
         int n, s, dd;
         logic ib;
         n  = 1 + int'($urandom % 8);
         s  = int'($urandom % 48);
         dd = 8'h80 + int'($urandom % 48);
         ib = 1'($urandom);
         do_reset();
         d = mkdesc(1, ib, 0, 8'(n), 16'(s), 16'(dd));
         dmem[0] = d;
         b3 = n_buf;
         wr_ctl(5'b01101);
         wait_wb("R4 random close");
         copy_chk("R4 random copy", s, dd, n);
         chk("R6 random irq", 64'(n_buf - b3), 64'(ib));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule